// File: doc/BRIEF.md
# Parameter Block Fetch and Validate Engine

This engine runs one diskette command. A start strobe comes with a 16-bit pointer. The engine then acts as a byte-wide bus master and reads an 11-byte parameter block, one byte per request/acknowledge handshake, at consecutive addresses that begin at the pointer. From the block it takes the channel word, the instruction, the record count, the track, the sector and the buffer address. The block layout is: byte 0 channel word, byte 1 instruction, byte 2 record count, byte 3 track, byte 4 sector, bytes 5 and 6 buffer address with the low byte first. Bytes 7 to 10 (block number, next-block pointer and a spare byte) are read but not used.

The engine checks the command against the drive status inputs in a fixed order. It then posts an error, or it carries out the command. Seek and recalibrate update a head position register kept for each drive. Read, write and format go to an external transfer engine through a one-cycle go pulse, and the engine waits for that engine's done. Every command ends with a result type and an error byte, a one-cycle done pulse, and (when the channel word allows it) the interrupt flip-flop being set.

The control FSM has five states. ST_IDLE waits for start. ST_FETCH reads the block. ST_CHECK runs the validation and dispatch. ST_XFER waits for the transfer engine. ST_FINISH posts the result. Its transitions are:
- IDLE→FETCH on start.
- FETCH→CHECK when the last byte is stored.
- CHECK→FINISH on an error, or on an operation that does not transfer.
- CHECK→XFER on a clean read, write or format.
- XFER→FINISH on transfer done.
- FINISH→IDLE always.

Top module: `pblk_engine`

## Requirements
- R1: After reset, busy, done and the interrupt are low, the result type is 10 with error byte 00, and every drive's head track and sector are 0.
- R2: An accepted start produces exactly 11 read requests, at addresses pointer+0 to pointer+10 in ascending order. Each request holds its address until it is acknowledged.
- R3: If the drive picked by instruction bits 5:4 is not ready, the command ends with result type 00 and error byte 0x80 (bit 7). This check wins over every other check.
- R4: For every opcode except recalibrate (3), an address error ends the command with type 00 and error byte 0x08 (bit 3). An address error is: sector 0, sector above 26, sector plus record count above 27, or track above 76.
- R5: Format (opcode 2) and write (opcode 6) to a drive whose protect input is high end with type 00 and error byte 0x20 (bit 5). No transfer starts. This check runs only after the address check passes, and no other opcode is subject to it.
- R6: A clean seek (opcode 1) stores the block's track and sector into the selected drive's head register. A clean recalibrate stores the sector and a track of 0. Other drives keep their values.
- R7: A clean no-op (0), seek, recalibrate, verify (5) or write-deleted (7) completes at once, with type 10, error byte 00 and no transfer go.
- R8: A clean read (4), write or format gives one transfer go pulse. During that pulse the opcode, unit, record count, track, sector and 16-bit buffer address are presented. Done comes only after the transfer-done input, with type 10 and error byte 00.
- R9: At completion the interrupt flip-flop is set only when channel word bits 5:4 are 00. Codes 01, 10 and 11 leave it unchanged. The clear input resets it.
- R10: Busy is high from the edge that accepts start until the end of the done cycle. Done lasts one cycle. Start strobes while busy are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start strobe |
| blk_ptr_i | input | 16 | Parameter block pointer, sampled with start |
| mem_rd_o | output | 1 | Read request |
| mem_addr_o | output | 16 | Read address |
| mem_ack_i | input | 1 | Read acknowledge, data valid |
| mem_data_i | input | 8 | Read data |
| drv_ready_i | input | 4 | Ready status, one bit per drive |
| drv_wprot_i | input | 4 | Write-protect status, one bit per drive |
| xfer_go_o | output | 1 | One-cycle transfer start |
| xfer_op_o | output | 3 | Transfer opcode |
| xfer_unit_o | output | 2 | Transfer drive |
| xfer_count_o | output | 8 | Record count |
| xfer_track_o | output | 8 | Track |
| xfer_sector_o | output | 8 | Starting sector |
| xfer_buf_o | output | 16 | Buffer address |
| xfer_done_i | input | 1 | Transfer engine finished |
| busy_o | output | 1 | Command in progress |
| done_o | output | 1 | One-cycle completion pulse |
| res_type_o | output | 2 | Result type (00 error, 10 success) |
| res_err_o | output | 8 | Error byte |
| irq_o | output | 1 | Interrupt flip-flop |
| irq_clr_i | input | 1 | Clears the interrupt flip-flop |
| hd_track_o | output | 32 | Head track per drive, drive n in bits 8n+7:8n |
| hd_sector_o | output | 32 | Head sector per drive, same packing |

## Verification
The in-line assertions check these rules on every cycle: the request-hold rule of the fetch, the single-cycle shape of done, fetch-last and transfer go, that busy rises on a start from idle, that an error byte always comes with type 00, that the interrupt rises only in a done cycle, and that head registers change only on a seek or recalibrate update. Only the directed scenarios can show the things that depend on block contents. These are the check priority (not ready over address, address over protect), the exact bounds of the sector, count and track limits, the recalibrate exemption, the per-drive scope of protect and of head updates, and the field values handed to the transfer engine.

// File: rtl/pblk_pkg.sv
package pblk_pkg;
    localparam int NUM_UNITS = 4;
    localparam int UNIT_W    = 2;

    typedef enum logic [2:0] {
        OP_NOP    = 3'd0,
        OP_SEEK   = 3'd1,
        OP_FORMAT = 3'd2,
        OP_RECAL  = 3'd3,
        OP_READ   = 3'd4,
        OP_VERIFY = 3'd5,
        OP_WRITE  = 3'd6,
        OP_WRDEL  = 3'd7
    } op_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_FETCH,
        ST_CHECK,
        ST_XFER,
        ST_FINISH
    } state_e;

    localparam logic [1:0] RT_ERR = 2'b00;
    localparam logic [1:0] RT_OK  = 2'b10;

    localparam logic [7:0] ERR_NOTRDY = 8'h80;
    localparam logic [7:0] ERR_ADDR   = 8'h08;
    localparam logic [7:0] ERR_WPROT  = 8'h20;
endpackage

// File: rtl/pblk_fetch.sv
module pblk_fetch #(
    parameter int PB_BYTES = 11,
    parameter int KEEP     = 7,
    parameter int AW       = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              go_i,
    input  logic [AW-1:0]     base_i,
    output logic              mem_rd_o,
    output logic [AW-1:0]     mem_addr_o,
    input  logic              mem_ack_i,
    input  logic [7:0]        mem_data_i,
    output logic              last_o,
    output logic [KEEP*8-1:0] blk_o
);
    localparam int IDX_W = $clog2(PB_BYTES);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(PB_BYTES - 1);

    logic          active;
    logic [IDX_W-1:0] idx;
    logic [AW-1:0] base_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            active <= 1'b0;
            idx    <= '0;
            base_q <= '0;
            last_o <= 1'b0;
            blk_o  <= '0;
        end else begin
            last_o <= 1'b0;
            if (go_i && !active) begin
                active <= 1'b1;
                idx    <= '0;
                base_q <= base_i;
            end else if (active && mem_ack_i) begin
                if (int'(idx) < KEEP)
                    blk_o[int'(idx)*8 +: 8] <= mem_data_i;
                if (idx == LAST_IDX) begin
                    active <= 1'b0;
                    last_o <= 1'b1;
                end else begin
                    idx <= idx + 1'b1;
                end
            end
        end
    end

    assign mem_rd_o   = active;
    assign mem_addr_o = base_q + AW'(idx);

    // R2
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd_o && !mem_ack_i) |=> (mem_rd_o && $stable(mem_addr_o)));

    // R2
    last_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        last_o |=> !last_o);
endmodule

// File: rtl/pblk_check.sv
module pblk_check
    import pblk_pkg::*;
#(
    parameter int MAX_SECTOR = 26,
    parameter int MAX_TRACK  = 76
) (
    input  op_e        op_i,
    input  logic [7:0] count_i,
    input  logic [7:0] track_i,
    input  logic [7:0] sector_i,
    input  logic       ready_i,
    input  logic       wprot_i,
    output logic [7:0] err_o
);
    logic [8:0] span;
    logic       addr_bad;
    logic       prot_hit;

    always_comb begin
        span     = {1'b0, sector_i} + {1'b0, count_i};
        addr_bad = (sector_i == 8'd0)
                || (sector_i > 8'(MAX_SECTOR))
                || (span > 9'(MAX_SECTOR + 1))
                || (track_i > 8'(MAX_TRACK));
        prot_hit = wprot_i && ((op_i == OP_FORMAT) || (op_i == OP_WRITE));
        if (!ready_i)
            err_o = ERR_NOTRDY;
        else if ((op_i != OP_RECAL) && addr_bad)
            err_o = ERR_ADDR;
        else if (prot_hit)
            err_o = ERR_WPROT;
        else
            err_o = 8'h00;
    end
endmodule

// File: rtl/pblk_headpos.sv
module pblk_headpos
    import pblk_pkg::*;
(
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   we_i,
    input  logic [UNIT_W-1:0]      unit_i,
    input  logic [7:0]             track_i,
    input  logic [7:0]             sector_i,
    output logic [NUM_UNITS*8-1:0] track_o,
    output logic [NUM_UNITS*8-1:0] sector_o
);
    for (genvar u = 0; u < NUM_UNITS; u++) begin : g_unit
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                track_o[u*8 +: 8]  <= 8'd0;
                sector_o[u*8 +: 8] <= 8'd0;
            end else if (we_i && (unit_i == UNIT_W'(u))) begin
                track_o[u*8 +: 8]  <= track_i;
                sector_o[u*8 +: 8] <= sector_i;
            end
        end
    end

    // R6
    hold_pos_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !we_i |=> ($stable(track_o) && $stable(sector_o)));
endmodule

// File: rtl/pblk_engine.sv
module pblk_engine
    import pblk_pkg::*;
#(
    parameter int AW         = 16,
    parameter int PB_BYTES   = 11,
    parameter int MAX_SECTOR = 26,
    parameter int MAX_TRACK  = 76
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   start_i,
    input  logic [AW-1:0]          blk_ptr_i,
    output logic                   mem_rd_o,
    output logic [AW-1:0]          mem_addr_o,
    input  logic                   mem_ack_i,
    input  logic [7:0]             mem_data_i,
    input  logic [NUM_UNITS-1:0]   drv_ready_i,
    input  logic [NUM_UNITS-1:0]   drv_wprot_i,
    output logic                   xfer_go_o,
    output logic [2:0]             xfer_op_o,
    output logic [UNIT_W-1:0]      xfer_unit_o,
    output logic [7:0]             xfer_count_o,
    output logic [7:0]             xfer_track_o,
    output logic [7:0]             xfer_sector_o,
    output logic [15:0]            xfer_buf_o,
    input  logic                   xfer_done_i,
    output logic                   busy_o,
    output logic                   done_o,
    output logic [1:0]             res_type_o,
    output logic [7:0]             res_err_o,
    output logic                   irq_o,
    input  logic                   irq_clr_i,
    output logic [NUM_UNITS*8-1:0] hd_track_o,
    output logic [NUM_UNITS*8-1:0] hd_sector_o
);
    localparam int KEEP = 7;

    state_e            state, nxt;
    logic [KEEP*8-1:0] blk;
    logic              fetch_last;
    logic [7:0]        chk_err;
    logic              hd_we;
    logic              enter_fin;

    logic [7:0]        cw, ins, cnt, trk, sec;
    logic [15:0]       bufa;
    op_e               op;
    logic [UNIT_W-1:0] unit;
    logic              is_xfer;

    assign cw   = blk[7:0];
    assign ins  = blk[15:8];
    assign cnt  = blk[23:16];
    assign trk  = blk[31:24];
    assign sec  = blk[39:32];
    assign bufa = blk[55:40];
    assign op   = op_e'(ins[2:0]);
    assign unit = ins[5:4];
    assign is_xfer = (op == OP_READ) || (op == OP_WRITE) || (op == OP_FORMAT);

    pblk_fetch #(.PB_BYTES(PB_BYTES), .KEEP(KEEP), .AW(AW)) u_fetch (
        .clk       (clk),
        .rst_n     (rst_n),
        .go_i      ((state == ST_IDLE) && start_i),
        .base_i    (blk_ptr_i),
        .mem_rd_o  (mem_rd_o),
        .mem_addr_o(mem_addr_o),
        .mem_ack_i (mem_ack_i),
        .mem_data_i(mem_data_i),
        .last_o    (fetch_last),
        .blk_o     (blk)
    );

    pblk_check #(.MAX_SECTOR(MAX_SECTOR), .MAX_TRACK(MAX_TRACK)) u_check (
        .op_i    (op),
        .count_i (cnt),
        .track_i (trk),
        .sector_i(sec),
        .ready_i (drv_ready_i[unit]),
        .wprot_i (drv_wprot_i[unit]),
        .err_o   (chk_err)
    );

    assign hd_we = (state == ST_CHECK) && (chk_err == 8'h00)
                && ((op == OP_SEEK) || (op == OP_RECAL));

    pblk_headpos u_pos (
        .clk     (clk),
        .rst_n   (rst_n),
        .we_i    (hd_we),
        .unit_i  (unit),
        .track_i ((op == OP_RECAL) ? 8'd0 : trk),
        .sector_i(sec),
        .track_o (hd_track_o),
        .sector_o(hd_sector_o)
    );

    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:   if (start_i) nxt = ST_FETCH;
            ST_FETCH:  if (fetch_last) nxt = ST_CHECK;
            ST_CHECK:  nxt = ((chk_err == 8'h00) && is_xfer) ? ST_XFER : ST_FINISH;
            ST_XFER:   if (xfer_done_i) nxt = ST_FINISH;
            ST_FINISH: nxt = ST_IDLE;
            default:   nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    assign enter_fin = (state != ST_FINISH) && (nxt == ST_FINISH);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            res_type_o <= RT_OK;
            res_err_o  <= 8'h00;
            irq_o      <= 1'b0;
            xfer_go_o  <= 1'b0;
        end else begin
            xfer_go_o <= (state == ST_CHECK) && (nxt == ST_XFER);
            if (enter_fin) begin
                if ((state == ST_CHECK) && (chk_err != 8'h00)) begin
                    res_type_o <= RT_ERR;
                    res_err_o  <= chk_err;
                end else begin
                    res_type_o <= RT_OK;
                    res_err_o  <= 8'h00;
                end
            end
            if (enter_fin && (cw[5:4] == 2'b00))
                irq_o <= 1'b1;
            else if (irq_clr_i)
                irq_o <= 1'b0;
        end
    end

    assign busy_o        = (state != ST_IDLE);
    assign done_o        = (state == ST_FINISH);
    assign xfer_op_o     = ins[2:0];
    assign xfer_unit_o   = unit;
    assign xfer_count_o  = cnt;
    assign xfer_track_o  = trk;
    assign xfer_sector_o = sec;
    assign xfer_buf_o    = bufa;

    // R10
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R10
    start_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !busy_o) |=> busy_o);

    // R8
    go_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_go_o |=> (!xfer_go_o && busy_o && !done_o));

    // R3
    err_type_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && (res_err_o != 8'h00)) |-> (res_type_o == RT_ERR));

    // R9
    irq_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_o) |-> done_o);
endmodule

// File: tb/tb_pblk_engine.sv
module tb_pblk_engine;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [15:0] blk_ptr_i = '0;
    logic        mem_rd_o;
    logic [15:0] mem_addr_o;
    logic        mem_ack_i = 1'b0;
    logic [7:0]  mem_data_i = '0;
    logic [3:0]  drv_ready_i = 4'hF;
    logic [3:0]  drv_wprot_i = 4'h0;
    logic        xfer_go_o;
    logic [2:0]  xfer_op_o;
    logic [1:0]  xfer_unit_o;
    logic [7:0]  xfer_count_o, xfer_track_o, xfer_sector_o;
    logic [15:0] xfer_buf_o;
    logic        xfer_done_i = 1'b0;
    logic        busy_o, done_o, irq_o;
    logic [1:0]  res_type_o;
    logic [7:0]  res_err_o;
    logic        irq_clr_i = 1'b0;
    logic [31:0] hd_track_o, hd_sector_o;

    always #10 clk = ~clk;

    pblk_engine dut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .blk_ptr_i(blk_ptr_i),
        .mem_rd_o(mem_rd_o), .mem_addr_o(mem_addr_o), .mem_ack_i(mem_ack_i),
        .mem_data_i(mem_data_i), .drv_ready_i(drv_ready_i), .drv_wprot_i(drv_wprot_i),
        .xfer_go_o(xfer_go_o), .xfer_op_o(xfer_op_o), .xfer_unit_o(xfer_unit_o),
        .xfer_count_o(xfer_count_o), .xfer_track_o(xfer_track_o),
        .xfer_sector_o(xfer_sector_o), .xfer_buf_o(xfer_buf_o),
        .xfer_done_i(xfer_done_i), .busy_o(busy_o), .done_o(done_o),
        .res_type_o(res_type_o), .res_err_o(res_err_o), .irq_o(irq_o),
        .irq_clr_i(irq_clr_i), .hd_track_o(hd_track_o), .hd_sector_o(hd_sector_o)
    );

    logic [7:0]  mem [0:1023];
    logic [15:0] rd_log [0:31];
    int          rd_cnt, go_cnt, done_cnt, pend;
    int          n_chk = 0, n_fail = 0;
    bit          xd_seen, xd_before;
    logic [2:0]  c_op;
    logic [1:0]  c_unit;
    logic [7:0]  c_cnt, c_trk, c_sec;
    logic [15:0] c_buf;
    logic [1:0]  r_type;
    logic [7:0]  r_err;
    logic        r_irq;

    always @(negedge clk) begin
        if (mem_ack_i) begin
            mem_ack_i = 1'b0;
        end else if (mem_rd_o) begin
            mem_ack_i  = 1'b1;
            mem_data_i = mem[mem_addr_o[9:0]];
            if (rd_cnt < 32) rd_log[rd_cnt] = mem_addr_o;
            rd_cnt++;
        end
        xfer_done_i = 1'b0;
        if (xfer_go_o) begin
            go_cnt++;
            c_op = xfer_op_o; c_unit = xfer_unit_o; c_cnt = xfer_count_o;
            c_trk = xfer_track_o; c_sec = xfer_sector_o; c_buf = xfer_buf_o;
            pend = 3;
        end else if (pend > 0) begin
            pend--;
            if (pend == 0) begin
                xfer_done_i = 1'b1;
                xd_seen = 1'b1;
            end
        end
        if (done_o) done_cnt++;
    end

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic summary();
        $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    task automatic run_block(input logic [15:0] ptr, input logic [7:0] cw,
                             input logic [7:0] ins, input logic [7:0] cnt,
                             input logic [7:0] trk, input logic [7:0] sec,
                             input logic [15:0] bufa, input bit extra_start);
        bit got;
        for (int i = 0; i < 11; i++) mem[(ptr + 16'(i)) & 16'h3FF] = 8'hEE;
        mem[ptr[9:0]]        = cw;
        mem[ptr[9:0] + 10'd1] = ins;
        mem[ptr[9:0] + 10'd2] = cnt;
        mem[ptr[9:0] + 10'd3] = trk;
        mem[ptr[9:0] + 10'd4] = sec;
        mem[ptr[9:0] + 10'd5] = bufa[7:0];
        mem[ptr[9:0] + 10'd6] = bufa[15:8];
        rd_cnt = 0; go_cnt = 0; done_cnt = 0; xd_seen = 1'b0;
        @(negedge clk);
        start_i = 1'b1; blk_ptr_i = ptr;
        @(negedge clk);
        start_i = 1'b0;
        chk("R10 busy after start", int'(busy_o), 1);
        if (extra_start) begin
            @(negedge clk);
            @(negedge clk);
            start_i = 1'b1; blk_ptr_i = 16'h0200;
            @(negedge clk);
            start_i = 1'b0;
        end
        got = 1'b0;
        for (int t = 0; t < 300 && !got; t++) begin
            @(negedge clk);
            if (done_o) begin
                got = 1'b1;
                r_type = res_type_o; r_err = res_err_o; r_irq = irq_o;
                xd_before = xd_seen;
            end
        end
        chk("R10 done reached", int'(got), 1);
        @(negedge clk);
        chk("R10 busy low after done", int'(busy_o), 0);
    endtask

    task automatic clear_irq();
        @(negedge clk); irq_clr_i = 1'b1;
        @(negedge clk); irq_clr_i = 1'b0;
    endtask

    task automatic t_reset();
        chk("R1 busy", int'(busy_o), 0);
        chk("R1 done", int'(done_o), 0);
        chk("R1 irq", int'(irq_o), 0);
        chk("R1 type", int'(res_type_o), 2);
        chk("R1 err", int'(res_err_o), 0);
        chk("R1 track", int'(hd_track_o), 0);
        chk("R1 sector", int'(hd_sector_o), 0);
    endtask

    task automatic t_fetch_nop();
        run_block(16'h0100, 8'h00, 8'h00, 8'd1, 8'd0, 8'd1, 16'h0000, 1'b0);
        chk("R2 read count", rd_cnt, 11);
        for (int i = 0; i < 11; i++) chk("R2 read address", int'(rd_log[i]), 32'h100 + i);
        chk("R7 nop type", int'(r_type), 2);
        chk("R7 nop err", int'(r_err), 0);
        chk("R7 nop no go", go_cnt, 0);
        chk("R9 irq set", int'(r_irq), 1);
        chk("R10 done width", done_cnt, 1);
        clear_irq();
        chk("R9 irq cleared", int'(irq_o), 0);
    endtask

    task automatic t_notready();
        drv_ready_i = 4'b1101;
        run_block(16'h0140, 8'h00, 8'h11, 8'd1, 8'd90, 8'd0, 16'h0000, 1'b0);
        chk("R3 type", int'(r_type), 0);
        chk("R3 err", int'(r_err), 8'h80);
        chk("R3 head unchanged", int'(hd_track_o[15:8]), 0);
        drv_ready_i = 4'hF;
        clear_irq();
    endtask

    task automatic t_address();
        run_block(16'h0100, 8'h10, 8'h05, 8'd1, 8'd0, 8'd0, 16'h0, 1'b0);
        chk("R4 sector zero", int'(r_err), 8'h08);
        chk("R4 sector zero type", int'(r_type), 0);
        run_block(16'h0100, 8'h10, 8'h05, 8'd1, 8'd0, 8'd27, 16'h0, 1'b0);
        chk("R4 sector 27", int'(r_err), 8'h08);
        run_block(16'h0100, 8'h10, 8'h05, 8'd8, 8'd0, 8'd20, 16'h0, 1'b0);
        chk("R4 span 28", int'(r_err), 8'h08);
        run_block(16'h0100, 8'h10, 8'h05, 8'd7, 8'd0, 8'd20, 16'h0, 1'b0);
        chk("R4 span 27 ok", int'(r_type), 2);
        run_block(16'h0100, 8'h10, 8'h05, 8'd1, 8'd77, 8'd1, 16'h0, 1'b0);
        chk("R4 track 77", int'(r_err), 8'h08);
        run_block(16'h0100, 8'h10, 8'h05, 8'd1, 8'd76, 8'd26, 16'h0, 1'b0);
        chk("R4 track 76 sector 26 ok", int'(r_err), 0);
        run_block(16'h0100, 8'h10, 8'h31, 8'd1, 8'd50, 8'd9, 16'h0, 1'b0);
        chk("R6 seek unit3 track", int'(hd_track_o[31:24]), 50);
        run_block(16'h0100, 8'h10, 8'h33, 8'd0, 8'd99, 8'd0, 16'h0, 1'b0);
        chk("R4 recal exempt type", int'(r_type), 2);
        chk("R6 recal track zero", int'(hd_track_o[31:24]), 0);
        chk("R6 recal sector", int'(hd_sector_o[31:24]), 0);
    endtask

    task automatic t_protect();
        drv_wprot_i = 4'b0001;
        run_block(16'h0100, 8'h10, 8'h06, 8'd1, 8'd3, 8'd1, 16'h0, 1'b0);
        chk("R5 write protected", int'(r_err), 8'h20);
        chk("R5 write protected no go", go_cnt, 0);
        run_block(16'h0100, 8'h10, 8'h02, 8'd1, 8'd3, 8'd1, 16'h0, 1'b0);
        chk("R5 format protected", int'(r_err), 8'h20);
        run_block(16'h0100, 8'h10, 8'h04, 8'd1, 8'd3, 8'd1, 16'h0, 1'b0);
        chk("R5 read ignores protect", int'(r_type), 2);
        chk("R5 read go", go_cnt, 1);
        run_block(16'h0100, 8'h10, 8'h06, 8'd1, 8'd3, 8'd0, 16'h0, 1'b0);
        chk("R5 address before protect", int'(r_err), 8'h08);
        run_block(16'h0100, 8'h10, 8'h16, 8'd1, 8'd3, 8'd1, 16'h0, 1'b0);
        chk("R5 other unit writes", int'(r_err), 0);
        chk("R5 other unit go", go_cnt, 1);
        drv_wprot_i = 4'h0;
    endtask

    task automatic t_seek();
        run_block(16'h0100, 8'h10, 8'h21, 8'd1, 8'd40, 8'd5, 16'h0, 1'b0);
        chk("R6 seek track", int'(hd_track_o[23:16]), 40);
        chk("R6 seek sector", int'(hd_sector_o[23:16]), 5);
        chk("R6 other drive", int'(hd_track_o[7:0]), 0);
        chk("R7 seek no go", go_cnt, 0);
        run_block(16'h0100, 8'h10, 8'h23, 8'd1, 8'd12, 8'd3, 16'h0, 1'b0);
        chk("R6 recal track", int'(hd_track_o[23:16]), 0);
        chk("R6 recal sector", int'(hd_sector_o[23:16]), 3);
    endtask

    task automatic t_xfer();
        run_block(16'h0100, 8'h10, 8'h14, 8'd3, 8'd10, 8'd4, 16'h2345, 1'b0);
        chk("R8 go count", go_cnt, 1);
        chk("R8 op", int'(c_op), 4);
        chk("R8 unit", int'(c_unit), 1);
        chk("R8 count", int'(c_cnt), 3);
        chk("R8 track", int'(c_trk), 10);
        chk("R8 sector", int'(c_sec), 4);
        chk("R8 buffer", int'(c_buf), 16'h2345);
        chk("R8 done after xfer", int'(xd_before), 1);
        chk("R8 type", int'(r_type), 2);
        run_block(16'h0100, 8'h10, 8'h16, 8'd1, 8'd1, 8'd1, 16'h0080, 1'b0);
        chk("R8 write op", int'(c_op), 6);
        run_block(16'h0100, 8'h10, 8'h12, 8'd1, 8'd1, 8'd1, 16'h0080, 1'b0);
        chk("R8 format op", int'(c_op), 2);
    endtask

    task automatic t_irq();
        clear_irq();
        run_block(16'h0100, 8'h10, 8'h00, 8'd1, 8'd0, 8'd1, 16'h0, 1'b0);
        chk("R9 disabled", int'(r_irq), 0);
        run_block(16'h0100, 8'h20, 8'h00, 8'd1, 8'd0, 8'd1, 16'h0, 1'b0);
        chk("R9 illegal code", int'(r_irq), 0);
    endtask

    task automatic t_wrdel();
        run_block(16'h0100, 8'h10, 8'h07, 8'd1, 8'd0, 8'd1, 16'h0, 1'b0);
        chk("R7 write deleted type", int'(r_type), 2);
        chk("R7 write deleted no go", go_cnt, 0);
    endtask

    task automatic t_busy();
        run_block(16'h0180, 8'h10, 8'h00, 8'd1, 8'd0, 8'd1, 16'h0, 1'b1);
        chk("R10 ignored start reads", rd_cnt, 11);
        chk("R10 ignored start last addr", int'(rd_log[10]), 32'h18A);
        chk("R10 single done", done_cnt, 1);
    endtask

    initial begin
        #(20 * 100000);
        n_fail++;
        $display("FAIL R10 watchdog actual=running expected=finished");
        summary();
        $finish;
    end

    initial begin
        pend = 0;
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_fetch_nop();
        t_notready();
        t_address();
        t_protect();
        t_seek();
        t_xfer();
        t_irq();
        t_wrdel();
        t_busy();
        summary();
        $finish;
    end
endmodule